// File: doc/BRIEF.md
# Four-Field Instruction Decoder

This block sits at the front of an execution pipeline. It splits each fixed 32-bit instruction into an 8-bit operation byte and three 8-bit operand specifiers. It returns the two source register indices to the register file in the same cycle. It takes the read data back and picks the second operand, either a register value or a zero-extended 8-bit constant. It also works out the load address, the relative branch target and the sequential next address. All results are captured in one register stage, so the datapath sees a complete decoded packet one cycle after the instruction is presented.

The operation byte is read as a major class in its upper four bits and a minor operation in its lower four. The implemented subset is the eight add/subtract opcodes of class 2, the octa load pair in class 8, and the whole of class 4 as relative branches. Every other operation byte is marked illegal, and all of its enables are held low.

Top module: `idec_top`

## Requirements
- R1: While reset is high, every registered output is zero at the following clock edge.
- R2: The source indices `ry_idx_o` and `rz_idx_o` equal instruction bits 15:8 and 7:0 combinationally. `dst_o` shows bits 23:16 of the instruction registered at the previous edge.
- R3: For a legal instruction, `cls_o` carries opcode bits 7:4 (the major class) and `minor_o` carries opcode bits 3:0.
- R4: Opcodes 0x20 to 0x27 assert `wr_en_o` and present the Y register data on `opa_o`. When opcode bit 0 is 0, `opb_o` is the Z register data. When it is 1, `opb_o` is the Z field zero-extended.
- R5: Opcodes 0x8C (Z from a register) and 0x8D (Z immediate) assert both `mem_rd_o` and `wr_en_o`. `addr_o` is `opa_o + opb_o` modulo 2^64.
- R6: Opcodes 0x40 to 0x4F assert `br_en_o` with `wr_en_o` low. `br_tgt_o` is the PC plus instruction bits 23:0 sign-extended and shifted left by 2, modulo 2^64.
- R7: For every valid instruction, `seq_pc_o` is the PC plus 4, modulo 2^64.
- R8: A valid instruction whose opcode lies outside the subset of R4 to R6 raises `illegal_o` and holds `wr_en_o`, `mem_rd_o` and `br_en_o` low.
- R9: When `valid_i` is low, the next cycle shows `valid_o`, `illegal_o` and all enables low.
- R10: Each decoded packet appears exactly one cycle after its instruction. Instructions presented back to back come out back to back, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Instruction word is meaningful this cycle |
| insn_i | input | 32 | Instruction word |
| pc_i | input | DATA_W | Address of the instruction |
| ry_data_i | input | DATA_W | Register file data for the Y index |
| rz_data_i | input | DATA_W | Register file data for the Z index |
| ry_idx_o | output | 8 | Y source index, combinational |
| rz_idx_o | output | 8 | Z source index, combinational |
| valid_o | output | 1 | Decoded packet valid |
| illegal_o | output | 1 | Opcode outside implemented subset |
| cls_o | output | 4 | Major class |
| minor_o | output | 4 | Minor operation |
| dst_o | output | 8 | Destination specifier |
| wr_en_o | output | 1 | Register write enable |
| mem_rd_o | output | 1 | Memory read enable |
| br_en_o | output | 1 | Relative branch |
| opa_o | output | DATA_W | First operand |
| opb_o | output | DATA_W | Second operand |
| addr_o | output | DATA_W | Load effective address |
| br_tgt_o | output | DATA_W | Branch target |
| seq_pc_o | output | DATA_W | Sequential next address |

## Verification
The bench builds the decoder with its default 64-bit data width. At that width, operands near the top of the range reach the modulo-2^64 wrap in the address adder, in the branch adder and in the PC increment. The branch offsets cover the most negative 24-bit value, minus one, and a forward step, which exercises sign extension across the full width. Illegal opcodes are taken from inside an implemented class (0x8B) as well as from outside every class.

// File: rtl/idec_pkg.sv
package idec_pkg;

    localparam int unsigned INSN_W  = 32;
    localparam int unsigned FIELD_W = 8;
    localparam int unsigned OFF_W   = 24;

    localparam logic [3:0] CLS_ADDSUB = 4'h2;
    localparam logic [3:0] CLS_BRANCH = 4'h4;
    localparam logic [3:0] CLS_LOAD   = 4'h8;
    localparam logic [3:0] LOAD_OCTA_HI = 3'h6;

    typedef struct packed {
        logic use_imm;
        logic wr;
        logic rd;
        logic br;
        logic bad;
    } ctrl_t;

    function automatic ctrl_t classify(input logic [7:0] op);
        ctrl_t c;
        c = '0;
        unique case (op[7:4])
            CLS_ADDSUB: begin
                if (op[3] == 1'b0) begin
                    c.wr      = 1'b1;
                    c.use_imm = op[0];
                end else begin
                    c.bad = 1'b1;
                end
            end
            CLS_LOAD: begin
                if (op[3:1] == LOAD_OCTA_HI[2:0]) begin
                    c.wr      = 1'b1;
                    c.rd      = 1'b1;
                    c.use_imm = op[0];
                end else begin
                    c.bad = 1'b1;
                end
            end
            CLS_BRANCH: c.br  = 1'b1;
            default:    c.bad = 1'b1;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/idec_fields.sv
module idec_fields
    import idec_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic [INSN_W-1:0]  insn,
    input  logic [DATA_W-1:0]  ry_data,
    input  logic [DATA_W-1:0]  rz_data,
    input  logic               use_imm,
    output logic [FIELD_W-1:0] op,
    output logic [FIELD_W-1:0] x_idx,
    output logic [FIELD_W-1:0] y_idx,
    output logic [FIELD_W-1:0] z_idx,
    output logic [OFF_W-1:0]   off,
    output logic [DATA_W-1:0]  opa,
    output logic [DATA_W-1:0]  opb
);
    localparam int unsigned PAD_W = DATA_W - FIELD_W;

    always_comb begin
        op    = insn[31:24];
        x_idx = insn[23:16];
        y_idx = insn[15:8];
        z_idx = insn[7:0];
        off   = insn[OFF_W-1:0];
        opa   = ry_data;
        opb   = use_imm ? {{PAD_W{1'b0}}, insn[7:0]} : rz_data;
    end
endmodule

// File: rtl/idec_target.sv
module idec_target
    import idec_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic [DATA_W-1:0] pc,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [OFF_W-1:0]  off,
    output logic [DATA_W-1:0] addr,
    output logic [DATA_W-1:0] br_tgt,
    output logic [DATA_W-1:0] seq_pc
);
    localparam int unsigned EXT_W = DATA_W - OFF_W - 2;
    localparam logic [DATA_W-1:0] STEP = DATA_W'(INSN_W / 8);

    logic [DATA_W-1:0] disp;

    always_comb begin
        disp   = {{EXT_W{off[OFF_W-1]}}, off, 2'b00};
        addr   = opa + opb;
        br_tgt = pc + disp;
        seq_pc = pc + STEP;
    end
endmodule

// File: rtl/idec_top.sv
module idec_top
    import idec_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [31:0]       insn_i,
    input  logic [DATA_W-1:0] pc_i,
    input  logic [DATA_W-1:0] ry_data_i,
    input  logic [DATA_W-1:0] rz_data_i,
    output logic [7:0]        ry_idx_o,
    output logic [7:0]        rz_idx_o,
    output logic              valid_o,
    output logic              illegal_o,
    output logic [3:0]        cls_o,
    output logic [3:0]        minor_o,
    output logic [7:0]        dst_o,
    output logic              wr_en_o,
    output logic              mem_rd_o,
    output logic              br_en_o,
    output logic [DATA_W-1:0] opa_o,
    output logic [DATA_W-1:0] opb_o,
    output logic [DATA_W-1:0] addr_o,
    output logic [DATA_W-1:0] br_tgt_o,
    output logic [DATA_W-1:0] seq_pc_o
);
    logic [FIELD_W-1:0] op, x_idx;
    logic [OFF_W-1:0]   off;
    logic [DATA_W-1:0]  opa, opb, addr, br_tgt, seq_pc;
    ctrl_t              ctrl;

    assign ctrl = classify(insn_i[31:24]);

    idec_fields #(.DATA_W(DATA_W)) fields_i (
        .insn    (insn_i),
        .ry_data (ry_data_i),
        .rz_data (rz_data_i),
        .use_imm (ctrl.use_imm),
        .op      (op),
        .x_idx   (x_idx),
        .y_idx   (ry_idx_o),
        .z_idx   (rz_idx_o),
        .off     (off),
        .opa     (opa),
        .opb     (opb)
    );

    idec_target #(.DATA_W(DATA_W)) target_i (
        .pc     (pc_i),
        .opa    (opa),
        .opb    (opb),
        .off    (off),
        .addr   (addr),
        .br_tgt (br_tgt),
        .seq_pc (seq_pc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o   <= 1'b0;
            illegal_o <= 1'b0;
            cls_o     <= '0;
            minor_o   <= '0;
            dst_o     <= '0;
            wr_en_o   <= 1'b0;
            mem_rd_o  <= 1'b0;
            br_en_o   <= 1'b0;
            opa_o     <= '0;
            opb_o     <= '0;
            addr_o    <= '0;
            br_tgt_o  <= '0;
            seq_pc_o  <= '0;
        end else begin
            valid_o   <= valid_i;
            illegal_o <= valid_i & ctrl.bad;
            cls_o     <= op[7:4];
            minor_o   <= op[3:0];
            dst_o     <= x_idx;
            wr_en_o   <= valid_i & ctrl.wr;
            mem_rd_o  <= valid_i & ctrl.rd;
            br_en_o   <= valid_i & ctrl.br;
            opa_o     <= opa;
            opb_o     <= opb;
            addr_o    <= addr;
            br_tgt_o  <= br_tgt;
            seq_pc_o  <= seq_pc;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!valid_o && !illegal_o && !wr_en_o && !mem_rd_o && !br_en_o)); // R1
    AST_DST_FROM_X: assert property (@(posedge clk) disable iff (rst) valid_i |=> dst_o == $past(insn_i[23:16])); // R2
    AST_BRANCH_NO_WRITE: assert property (@(posedge clk) disable iff (rst) br_en_o |-> !wr_en_o && !mem_rd_o); // R6
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst) valid_i |=> seq_pc_o == $past(pc_i) + DATA_W'(4)); // R7
    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (rst) illegal_o |-> !(wr_en_o || mem_rd_o || br_en_o)); // R8
    AST_IDLE_BUBBLE: assert property (@(posedge clk) disable iff (rst) !valid_i |=> !valid_o && !illegal_o && !wr_en_o && !mem_rd_o && !br_en_o); // R9
    AST_ONE_KIND: assert property (@(posedge clk) disable iff (rst) $onehot0({illegal_o, br_en_o, mem_rd_o})); // R8
endmodule

// File: tb/idec_top_tb_top.sv
module idec_top_tb_top;
    localparam int unsigned W = 64;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         valid_i = 1'b0;
    logic [31:0]  insn_i = '0;
    logic [W-1:0] pc_i = '0, ry_data_i = '0, rz_data_i = '0;
    logic [7:0]   ry_idx_o, rz_idx_o, dst_o;
    logic         valid_o, illegal_o, wr_en_o, mem_rd_o, br_en_o;
    logic [3:0]   cls_o, minor_o;
    logic [W-1:0] opa_o, opb_o, addr_o, br_tgt_o, seq_pc_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    idec_top #(.DATA_W(W)) dut_i (
        .clk(clk), .rst(rst), .valid_i(valid_i), .insn_i(insn_i), .pc_i(pc_i),
        .ry_data_i(ry_data_i), .rz_data_i(rz_data_i),
        .ry_idx_o(ry_idx_o), .rz_idx_o(rz_idx_o), .valid_o(valid_o),
        .illegal_o(illegal_o), .cls_o(cls_o), .minor_o(minor_o), .dst_o(dst_o),
        .wr_en_o(wr_en_o), .mem_rd_o(mem_rd_o), .br_en_o(br_en_o),
        .opa_o(opa_o), .opb_o(opb_o), .addr_o(addr_o), .br_tgt_o(br_tgt_o),
        .seq_pc_o(seq_pc_o)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive on falling edge; the packet is visible after the next rising edge
    task automatic issue(input logic v, input logic [31:0] ins, input logic [W-1:0] pc,
                         input logic [W-1:0] y, input logic [W-1:0] z);
        @(negedge clk);
        valid_i = v; insn_i = ins; pc_i = pc; ry_data_i = y; rz_data_i = z;
    endtask

    task automatic settle();
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    function automatic logic [W-1:0] tgt(input logic [W-1:0] pc, input logic [23:0] off);
        return pc + {{(W-26){off[23]}}, off, 2'b00};
    endfunction

    task automatic t_reset();
        chk("R1 valid", W'(valid_o), 0);
        chk("R1 illegal", W'(illegal_o), 0);
        chk("R1 enables", W'({wr_en_o, mem_rd_o, br_en_o}), 0);
        chk("R1 seq_pc", seq_pc_o, 0);
        chk("R1 opa", opa_o, 0);
    endtask

    task automatic t_add_reg();
        issue(1'b1, 32'h20_0A_0B_0C, 64'h100, 64'h1111, 64'h2222);
        #1;
        chk("R2 ry_idx", W'(ry_idx_o), 64'h0B);
        chk("R2 rz_idx", W'(rz_idx_o), 64'h0C);
        settle();
        chk("R2 dst", W'(dst_o), 64'h0A);
        chk("R3 cls", W'(cls_o), 2);
        chk("R3 minor", W'(minor_o), 0);
        chk("R4 wr_en", W'(wr_en_o), 1);
        chk("R4 opa", opa_o, 64'h1111);
        chk("R4 opb reg", opb_o, 64'h2222);
        chk("R10 valid", W'(valid_o), 1);
    endtask

    task automatic t_sub_imm();
        issue(1'b1, 32'h25_03_04_FF, 64'h200, 64'h50, 64'hDEAD);
        settle();
        chk("R3 minor sub", W'(minor_o), 5);
        chk("R4 opb imm", opb_o, 64'hFF);
        chk("R4 wr_en imm", W'(wr_en_o), 1);
        chk("R4 no mem", W'(mem_rd_o), 0);
    endtask

    task automatic t_load();
        issue(1'b1, 32'h8C_07_01_02, 64'h300, 64'hFFFF_FFFF_FFFF_FFF0, 64'h20);
        settle();
        chk("R5 mem_rd", W'(mem_rd_o), 1);
        chk("R5 wr_en", W'(wr_en_o), 1);
        chk("R5 addr wrap", addr_o, 64'h10);
        chk("R3 cls load", W'(cls_o), 8);
        issue(1'b1, 32'h8D_07_01_08, 64'h300, 64'h1000, 64'h9999);
        settle();
        chk("R5 addr imm", addr_o, 64'h1008);
    endtask

    task automatic t_branch();
        issue(1'b1, 32'h4A_00_00_10, 64'h1000, 0, 0);
        settle();
        chk("R6 br_en", W'(br_en_o), 1);
        chk("R6 no write", W'(wr_en_o), 0);
        chk("R6 fwd target", br_tgt_o, tgt(64'h1000, 24'h000010));
        issue(1'b1, 32'h41_FF_FF_FF, 64'h1000, 0, 0);
        settle();
        chk("R6 back one", br_tgt_o, 64'hFFC);
        issue(1'b1, 32'h4F_80_00_00, 64'h4000_0000, 0, 0);
        settle();
        chk("R6 min offset", br_tgt_o, 64'h3E00_0000);
        chk("R3 minor br", W'(minor_o), 15);
    endtask

    task automatic t_seq_wrap();
        issue(1'b1, 32'h20_00_00_00, 64'hFFFF_FFFF_FFFF_FFFC, 0, 0);
        settle();
        chk("R7 seq wrap", seq_pc_o, 0);
    endtask

    task automatic t_illegal();
        logic [7:0] ops [3] = '{8'h00, 8'h8B, 8'hFE};
        for (int i = 0; i < 3; i++) begin
            issue(1'b1, {ops[i], 24'h010203}, 64'h40, 1, 2);
            settle();
            chk("R8 illegal", W'(illegal_o), 1);
            chk("R8 enables low", W'({wr_en_o, mem_rd_o, br_en_o}), 0);
        end
    endtask

    task automatic t_idle();
        issue(1'b0, 32'h20_01_02_03, 64'h80, 1, 2);
        settle();
        chk("R9 valid low", W'(valid_o), 0);
        chk("R9 enables low", W'({illegal_o, wr_en_o, mem_rd_o, br_en_o}), 0);
    endtask

    task automatic t_back_to_back();
        issue(1'b1, 32'h21_05_00_07, 64'h500, 64'h10, 0);
        issue(1'b1, 32'h44_00_00_01, 64'h504, 0, 0);
        chk("R10 first dst", W'(dst_o), 5);
        chk("R10 first opb", opb_o, 7);
        settle();
        chk("R10 second br", W'(br_en_o), 1);
        chk("R10 second tgt", br_tgt_o, 64'h508);
        chk("R10 second seq", seq_pc_o, 64'h508);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_add_reg();
        t_sub_imm();
        t_load();
        t_branch();
        t_seq_wrap();
        t_illegal();
        t_idle();
        t_back_to_back();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule